// File: doc/BRIEF.md
# Data EEPROM Control Register Unit

This block manages a small nonvolatile byte array on behalf of a processor that talks to it over a synchronous register bus. Four registers are reachable through a 2-bit select: a control/status register, an unlock register that holds no data, an address register and a data register. Software places an address in the address register and sets the read-start bit to fetch a byte. It can instead place an address and a byte, arm the unlock register with two key bytes, and set the write-start bit to program the byte. Programming takes a parameterised number of clock cycles. When it finishes, the block raises an interrupt flag that stays set until software acknowledges it.

Two reset inputs are kept apart. Power-on reset returns every control bit to its idle value. A warm reset comes from an external pin, a watchdog or a brown-out. If it arrives while a byte is being programmed, the unprogrammed byte is abandoned and the error bit is set. The address and data registers are cleared, so software can spot the loss and program the byte again. The array itself survives both resets.

Top module: `eeprom_ctrl_unit`

## Requirements
- R1: Register select codes are 0 = control, 1 = unlock, 2 = address, 3 = data. The control register holds the error bit at bit 3, write-enable at bit 2, write-start at bit 1 and read-start at bit 0. Control bits 7..4 always read as 0. Read data is 0 whenever the read strobe is low.
- R2: Software can set the read-start and write-start bits but never clear them. Only the block clears them.
- R3: Setting read-start loads the array byte at the current address into the data register on the next clock edge, and read-start clears on that same edge.
- R4: With write-enable at 0, setting write-start has no effect, even after a correct unlock.
- R5: A warm reset while a write is under way sets the error bit. After any warm reset the address and data registers read 0.
- R6: When a write finishes, irq_flag goes to 1. It stays at 1 until irq_clr is pulsed, and a finishing write wins over a clear in the same cycle.
- R7: The unlock register always reads as 0x00.
- R8: A write that finishes normally leaves the error bit at 0 and programs the data byte at the address.
- R9: Write-start takes effect only if the two bus writes just before it went to the unlock register with 0x55 and then 0xAA. Any other bus write in between breaks the unlock.
- R10: While a write is under way, bus writes to the control, address and data registers are ignored. Write-start stays set for exactly WRITE_CYCLES cycles.
- R11: Power-on reset clears the error bit, write-enable, both start bits, irq_flag and the unlock state. A warm reset keeps the array and irq_flag, clears write-enable, both start bits and the unlock state, and leaves the error bit unchanged when no write is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset (pin, watchdog, brown-out), active low, sampled on clk |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_rdata | output | 8 | Combinational read data |
| irq_clr | input | 1 | Software acknowledge of the write-complete flag |
| irq_flag | output | 1 | Write-complete interrupt flag |

## Verification
Programming is tried four ways: a correct unlock with write-enable at 1, a correct unlock with write-enable at 0, write-enable at 1 with no unlock, and an unlock broken by an address write. Only the first sets write-start, so the four cases separate the enable gate from the key tracker. Reads after each completed write show whether the byte actually reached the array. A second group stresses the write window itself. It tries to clear write-start, to overwrite the address, and to cut the write with a warm reset. It also compares warm reset during a write, warm reset while idle, and power-on reset, so that error-bit setting, register clearing and array retention can each be told apart.

// File: rtl/eeu_pkg.sv
package eeu_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_SEQ  = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_FIRST = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  localparam int CB_ERR = 3;
  localparam int CB_EN  = 2;
  localparam int CB_WR  = 1;
  localparam int CB_RD  = 0;

  // Control/status register image: upper nibble always zero.
  function automatic logic [7:0] pack_ctrl(logic err, logic en, logic wr, logic rd);
    return {4'b0000, err, en, wr, rd};
  endfunction

  // Unlock tracker next state for one cycle of bus activity.
  function automatic unlock_e next_unlock(unlock_e cur, logic seq_we, logic other_we,
                                          logic [7:0] d, logic [7:0] k1, logic [7:0] k2);
    unlock_e nx;
    nx = cur;
    if (other_we)
      nx = UL_IDLE;
    else if (seq_we) begin
      if (d == k1)
        nx = UL_FIRST;
      else if (d == k2 && cur == UL_FIRST)
        nx = UL_ARMED;
      else
        nx = UL_IDLE;
    end
    return nx;
  endfunction

endpackage

// File: rtl/eeu_unlock.sv
module eeu_unlock
  import eeu_pkg::*;
#(
  parameter int          DW   = 8,
  parameter logic [7:0]  KEY1 = 8'h55,
  parameter logic [7:0]  KEY2 = 8'hAA
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          warm_rst_n,
  input  logic          busy,
  input  logic          seq_we,
  input  logic          other_we,
  input  logic [DW-1:0] wdata,
  output logic          armed
);

  unlock_e st_q;
  unlock_e st_d;

  always_comb begin
    if (!warm_rst_n || busy)
      st_d = UL_IDLE;
    else
      st_d = next_unlock(st_q, seq_we, other_we, wdata[7:0], KEY1, KEY2);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);

  AST_ARM_NEEDS_SECOND_KEY: assert property (@(posedge clk) disable iff (!por_n)
    $rose(armed) |-> ($past(seq_we) && $past(wdata[7:0]) == KEY2)); // R9

  AST_OTHER_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!por_n)
    other_we |=> !armed); // R9

endmodule

// File: rtl/eeu_write_timer.sv
module eeu_write_timer #(
  parameter int WRITE_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && warm_rst_n && (cnt_q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!warm_rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!por_n)
    busy_q |-> (cnt_q <= LAST)); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!por_n)
    done |=> !busy_q); // R10

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    !busy_q |-> (cnt_q == '0)); // R10

endmodule

// File: rtl/eeu_array.sv
module eeu_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/eeprom_ctrl_unit.sv
module eeprom_ctrl_unit
  import eeu_pkg::*;
#(
  parameter int         AW           = 8,
  parameter int         DW           = 8,
  parameter int         WRITE_CYCLES = 16,
  parameter logic [7:0] KEY1         = 8'h55,
  parameter logic [7:0] KEY2         = 8'hAA
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          warm_rst_n,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_clr,
  output logic          irq_flag
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          wren_q;
  logic          wrerr_q;
  logic          rd_q;
  logic          irq_q;

  // Named internal events
  logic          wr_busy;
  logic          wr_done;
  logic          armed;
  logic          seq_we;
  logic          other_we;
  logic          ctrl_we;
  logic          addr_we;
  logic          data_we;
  logic          start_wr;
  logic          start_rd;
  logic [DW-1:0] arr_rdata;

  assign seq_we   = bus_we && (bus_sel == SEL_SEQ);
  assign other_we = bus_we && (bus_sel != SEL_SEQ);
  assign ctrl_we  = bus_we && (bus_sel == SEL_CTRL) && !wr_busy;
  assign addr_we  = bus_we && (bus_sel == SEL_ADDR) && !wr_busy;
  assign data_we  = bus_we && (bus_sel == SEL_DATA) && !wr_busy;
  assign start_wr = ctrl_we && bus_wdata[CB_WR] && wren_q && armed && warm_rst_n;
  assign start_rd = ctrl_we && bus_wdata[CB_RD] && !start_wr;

  eeu_unlock #(.DW(DW), .KEY1(KEY1), .KEY2(KEY2)) u_unlock (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .busy       (wr_busy),
    .seq_we     (seq_we),
    .other_we   (other_we),
    .wdata      (bus_wdata),
    .armed      (armed)
  );

  eeu_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .start      (start_wr),
    .busy       (wr_busy),
    .done       (wr_done)
  );

  eeu_array #(.AW(AW), .DW(DW)) u_array (
    .clk   (clk),
    .we    (wr_done),
    .waddr (addr_q),
    .wdata (data_q),
    .raddr (addr_q),
    .rdata (arr_rdata)
  );

  // Address register
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          addr_q <= '0;
    else if (!warm_rst_n) addr_q <= '0;
    else if (addr_we)    addr_q <= bus_wdata[AW-1:0];
  end

  // Data register: array read has priority over a bus write
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          data_q <= '0;
    else if (!warm_rst_n) data_q <= '0;
    else if (rd_q)       data_q <= arr_rdata;
    else if (data_we)    data_q <= bus_wdata;
  end

  // Control bits
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wren_q  <= 1'b0;
      wrerr_q <= 1'b0;
      rd_q    <= 1'b0;
    end else if (!warm_rst_n) begin
      wren_q  <= 1'b0;
      rd_q    <= 1'b0;
      if (wr_busy) wrerr_q <= 1'b1;
    end else begin
      if (rd_q)          rd_q <= 1'b0;
      else if (start_rd) rd_q <= 1'b1;
      if (ctrl_we) begin
        wren_q  <= bus_wdata[CB_EN];
        wrerr_q <= bus_wdata[CB_ERR];
      end
      if (wr_done) wrerr_q <= 1'b0;
    end
  end

  // Write-complete flag: survives warm reset, set beats clear
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       irq_q <= 1'b0;
    else if (wr_done) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  assign irq_flag = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (bus_sel)
        SEL_CTRL: bus_rdata = pack_ctrl(wrerr_q, wren_q, wr_busy, rd_q);
        SEL_SEQ:  bus_rdata = '0;
        SEL_ADDR: bus_rdata = DW'(addr_q);
        SEL_DATA: bus_rdata = data_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (bus_re && bus_sel == SEL_CTRL) |-> (bus_rdata[7:4] == 4'h0)); // R1

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    !bus_re |-> (bus_rdata == '0)); // R1

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (wr_busy && !wr_done && warm_rst_n) |=> wr_busy); // R2

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    rd_q |=> !rd_q); // R3

  AST_WR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wr_busy) |-> $past(wren_q)); // R4

  AST_WARM_SETS_ERR: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && wr_busy) |=> wrerr_q); // R5

  AST_WARM_CLEARS_REGS: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> (addr_q == '0 && data_q == '0)); // R5

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!por_n)
    wr_done |=> irq_q); // R6

  AST_SEQ_READS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (bus_re && bus_sel == SEL_SEQ) |-> (bus_rdata == '0)); // R7

  AST_DONE_CLEARS_ERR: assert property (@(posedge clk) disable iff (!por_n)
    wr_done |=> !wrerr_q); // R8

  AST_WR_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wr_busy) |-> $past(armed)); // R9

  AST_BUSY_ADDR_STABLE: assert property (@(posedge clk) disable iff (!por_n)
    (wr_busy && warm_rst_n) |=> $stable(addr_q)); // R10

  AST_WARM_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && irq_q && !irq_clr) |=> irq_q); // R11

endmodule

// File: tb/eeprom_ctrl_unit_tb.sv
module eeprom_ctrl_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 16;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       warm_rst_n = 1'b1;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_clr = 1'b0;
  logic       irq_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct {
    string      tag;
    string      what;
    logic [7:0] exp;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_ctrl_unit #(.WRITE_CYCLES(WCYC)) u_dut (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .irq_clr    (irq_clr),
    .irq_flag   (irq_flag)
  );

  // Expected control image, computed from the bit layout of R1
  function automatic logic [7:0] ctl(bit err, bit en, bit wr, bit rd);
    return {4'h0, err, en, wr, rd};
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected read results and compares them mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (bus_re && sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(it.tag, it.what, bus_rdata, it.exp);
      end
    end
  end

  task automatic bus_write(logic [1:0] sel, logic [7:0] val);
    @(negedge clk);
    bus_sel = sel; bus_wdata = val; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] sel, logic [7:0] exp, string tag, string what);
    exp_item_t it;
    @(negedge clk);
    it.tag = tag; it.what = what; it.exp = exp;
    sb_q.push_back(it);
    bus_sel = sel; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic unlock();
    bus_write(2'd1, 8'h55);
    bus_write(2'd1, 8'hAA);
  endtask

  task automatic warm_pulse();
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    por_n = 1'b1;
    idle(2);

    // Reset state
    bus_read(2'd0, ctl(0,0,0,0), "R11", "control after power-on");
    check("R11", "irq after power-on", {7'd0, irq_flag}, 8'h00);
    bus_read(2'd1, 8'h00, "R7", "unlock register read");
    check("R1", "idle bus read", bus_rdata, 8'h00);

    // Address/data registers
    bus_write(2'd2, 8'h10);
    bus_write(2'd3, 8'hA5);
    bus_read(2'd2, 8'h10, "R1", "address register");
    bus_read(2'd3, 8'hA5, "R1", "data register");

    // Upper nibble ignored, error bit writable
    bus_write(2'd0, 8'hF0);
    bus_read(2'd0, ctl(0,0,0,0), "R1", "upper bits read zero");
    bus_write(2'd0, 8'h08);
    bus_read(2'd0, ctl(1,0,0,0), "R1", "error bit writable");
    bus_write(2'd0, 8'h00);

    // Unlock but no enable
    unlock();
    bus_write(2'd0, 8'h02);
    bus_read(2'd0, ctl(0,0,0,0), "R4", "write-start without enable");

    // Enable but no unlock
    bus_write(2'd0, 8'h04);
    bus_write(2'd0, 8'h06);
    bus_read(2'd0, ctl(0,1,0,0), "R9", "write-start without unlock");

    // Broken unlock
    bus_write(2'd1, 8'h55);
    bus_write(2'd2, 8'h10);
    bus_write(2'd1, 8'hAA);
    bus_write(2'd0, 8'h06);
    bus_read(2'd0, ctl(0,1,0,0), "R9", "unlock broken by address write");

    // Proper write of A5 to 0x10
    unlock();
    bus_write(2'd0, 8'h06);
    bus_read(2'd0, ctl(0,1,1,0), "R9", "write started after unlock");
    bus_write(2'd0, 8'h00);
    bus_write(2'd2, 8'h33);
    bus_read(2'd0, ctl(0,1,1,0), "R2", "software cannot clear write-start");
    bus_read(2'd2, 8'h10, "R10", "address write ignored while busy");
    idle(WCYC + 4);
    bus_read(2'd0, ctl(0,1,0,0), "R10", "write-start cleared after write");
    check("R6", "irq set at completion", {7'd0, irq_flag}, 8'h01);
    idle(5);
    check("R6", "irq held", {7'd0, irq_flag}, 8'h01);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check("R6", "irq cleared by ack", {7'd0, irq_flag}, 8'h00);

    // Read back
    bus_write(2'd3, 8'h00);
    bus_write(2'd0, 8'h05);
    bus_read(2'd0, ctl(0,1,0,0), "R3", "read-start self-clears");
    bus_read(2'd3, 8'hA5, "R8", "byte programmed into array");

    // Warm reset during a write of 5A to 0x10
    bus_write(2'd3, 8'h5A);
    unlock();
    bus_write(2'd0, 8'h06);
    idle(3);
    warm_pulse();
    bus_read(2'd0, ctl(1,0,0,0), "R5", "error set by warm reset in write");
    bus_read(2'd2, 8'h00, "R5", "address cleared by warm reset");
    bus_read(2'd3, 8'h00, "R5", "data cleared by warm reset");
    check("R6", "no irq for aborted write", {7'd0, irq_flag}, 8'h00);
    bus_write(2'd2, 8'h10);
    bus_write(2'd0, 8'h09);
    bus_read(2'd3, 8'hA5, "R11", "array kept through warm reset");

    // Normal completion clears error
    bus_write(2'd3, 8'h3C);
    bus_write(2'd0, 8'h0C);
    unlock();
    bus_write(2'd0, 8'h0E);
    idle(WCYC + 4);
    bus_read(2'd0, ctl(0,1,0,0), "R8", "normal completion clears error");
    bus_write(2'd3, 8'h00);
    bus_write(2'd0, 8'h05);
    bus_read(2'd3, 8'h3C, "R8", "new byte programmed");

    // Warm reset while idle: error bit untouched, irq kept
    bus_write(2'd0, 8'h0C);
    warm_pulse();
    bus_read(2'd0, ctl(1,0,0,0), "R11", "idle warm reset keeps error clears enable");
    check("R11", "irq kept through warm reset", {7'd0, irq_flag}, 8'h01);

    // Power-on reset
    @(negedge clk); por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    bus_read(2'd0, ctl(0,0,0,0), "R11", "control after second power-on");
    check("R11", "irq cleared by power-on", {7'd0, irq_flag}, 8'h00);
    bus_write(2'd2, 8'h10);
    bus_write(2'd0, 8'h01);
    bus_read(2'd3, 8'h3C, "R11", "array kept through power-on");

    idle(2);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule